// File: doc/BRIEF.md
# Burst Bus Cycle Controller

This block runs the processor side of a 64-bit external bus. An internal requester hands over one access at a time through a valid/ready port. The controller buffers the access and pulses the address strobe for one clock. It then collects data beats that the system marks with burst-ready. A read that asks for a line fill becomes four beats when the system also returns cache-enable. Any other access finishes on one beat. Each beat is passed back to the requester with its index, and the last beat carries a done flag.

The system can interrupt the bus in two ways. Back-off takes the bus on the clock it is seen. Any beat offered in that clock is thrown away, and once back-off is released the buffered cycle is started again from its first beat. A hold request is granted only between cycles and never while a locked sequence is open. The lock output covers a run of locked cycles, from the strobe of the first one to the last beat of the cycle flagged as final.

Back-pressure rules: the request port accepts an access in a clock where `req_valid` and `req_ready` are both high. The requester keeps the request fields stable while it waits. `req_ready` is high only when the bus is idle, not backed off, not held, and either no lock is open or the request is itself locked. The response side has no back-pressure. Each beat is presented for exactly one clock.

Top module: `bbc_top`

## Requirements
- R1: After reset, `bus_ads`, `bus_hlda`, `bus_lock`, `bus_float` and `rsp_valid` are 0 and `req_ready` is 1 while hold and back-off are low.
- R2: An accepted request drives `bus_ads` high for exactly the next clock, with the buffered address on `bus_addr`. A burst-ready in that clock produces no beat.
- R3: A read with `req_cacheable`=1 and cache-enable high at its sampling point delivers exactly four beats, with `rsp_beat` 0,1,2,3 in order and `rsp_done` on beat 3. `bus_cache` is high throughout the cycle.
- R4: A write, a read with `req_cacheable`=0, or a read that samples cache-enable low completes on its first accepted beat, with `rsp_beat`=0 and `rsp_done`=1.
- R5: Cache-enable is sampled once per cycle attempt, at the first clock from the second clock onward in which next-address or burst-ready is high. Later cache-enable values do not change the beat count.
- R6: Back-off high makes `bus_float` 1 in the same clock and suppresses any beat in that clock. After back-off falls, `bus_ads` repeats with the same address and beats restart at index 0.
- R7: A hold request is granted (`bus_hlda`=1 from the next clock) only while the bus is idle and no lock is open. A request raised during a cycle is granted the clock after the cycle ends.
- R8: `bus_hlda` falls in the clock after the one in which `bus_hold` is seen low.
- R9: `bus_lock` rises with the strobe of a request that has `req_lock`=1. It stays high across idle gaps until the clock after the last beat of a locked request with `req_lock_end`=1. While it is high, requests with `req_lock`=0 are not accepted.
- R10: `req_ready` is 0 during an active cycle, during back-off, and while a grantable hold is pending.
- R11: `rsp_valid` is 1 exactly in clocks with an accepted beat. In those clocks `rsp_data` equals `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | Read asks for a line fill |
| req_lock | input | 1 | Request belongs to a locked sequence |
| req_lock_end | input | 1 | Final request of the locked sequence |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Beat accepted this clock |
| rsp_beat | output | BEAT_W | Index of the beat |
| rsp_data | output | DATA_W | Beat data |
| rsp_done | output | 1 | Last beat of the cycle |
| bus_ads | output | 1 | Address strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_write | output | 1 | Cycle direction |
| bus_cache | output | 1 | Cycle is a cacheable line read |
| bus_lock | output | 1 | Locked sequence open |
| bus_wdata | output | DATA_W | Write data to bus |
| bus_rdata | input | DATA_W | Read data from bus |
| bus_brdy | input | 1 | Burst-ready |
| bus_ken | input | 1 | Cache-enable |
| bus_na | input | 1 | Next-address hint |
| bus_boff | input | 1 | Back-off |
| bus_hold | input | 1 | Hold request |
| bus_hlda | output | 1 | Hold acknowledge |
| bus_float | output | 1 | Bus signals released |

## Verification
Two pairs of events can meet in one clock.

- **Back-off and burst-ready.** The bench raises back-off in the same clock as a burst-ready at a chosen beat, including the middle of a line fill. It expects no beat that clock, a floated bus at once, and a re-issued strobe with the original address followed by beats counted from zero.
- **Hold and an open cycle or lock.** The bench raises hold while a cycle is running and while a locked sequence sits idle. It expects no acknowledge until the cycle ends or the lock closes.

Cache-enable is toggled between next-address and burst-ready to show the first sample wins.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_BOFF = 3'd3,
    ST_HOLD = 3'd4
  } bbc_state_e;
endpackage

// File: rtl/bbc_req_buf.sv
module bbc_req_buf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  logic              in_line,
  input  logic              in_lock_end,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_write,
  output logic              cur_line,
  output logic              cur_lock_end,
  output logic [DATA_W-1:0] cur_wdata
);
  // Holds the accepted access so a restart after back-off re-issues it unchanged.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr     <= '0;
      cur_write    <= 1'b0;
      cur_line     <= 1'b0;
      cur_lock_end <= 1'b0;
      cur_wdata    <= '0;
    end else if (load) begin
      cur_addr     <= in_addr;
      cur_write    <= in_write;
      cur_line     <= in_line;
      cur_lock_end <= in_lock_end;
      cur_wdata    <= in_wdata;
    end
  end
endmodule

// File: rtl/bbc_beat_ctr.sv
module bbc_beat_ctr #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat_ok,
  input  logic              na_ok,
  input  logic              ken,
  input  logic              want_line,
  output logic [BEAT_W-1:0] beat,
  output logic              last
);
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] beat_q;
  logic              ken_seen_q;
  logic              ken_val_q;
  logic              ken_eff;
  logic              line_now;

  // The first of next-address or burst-ready freezes the cache-enable decision.
  assign ken_eff  = ken_seen_q ? ken_val_q : ken;
  assign line_now = want_line & ken_eff;
  assign last     = beat_ok & (~line_now | (beat_q == LAST_IDX));
  assign beat     = beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q     <= '0;
      ken_seen_q <= 1'b0;
      ken_val_q  <= 1'b0;
    end else if (clear) begin
      beat_q     <= '0;
      ken_seen_q <= 1'b0;
      ken_val_q  <= 1'b0;
    end else if (beat_ok) begin
      ken_seen_q <= 1'b1;
      ken_val_q  <= ken_eff;
      beat_q     <= last ? '0 : beat_q + 1'b1;
    end else if (na_ok && !ken_seen_q) begin
      ken_seen_q <= 1'b1;
      ken_val_q  <= ken;
    end
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && !last && !clear) |=> (beat_q == $past(beat_q) + 1'b1)); // R3
  AST_KEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ken_seen_q && !clear) |=> (ken_val_q == $past(ken_val_q))); // R5
endmodule

// File: rtl/bbc_seq.sv
module bbc_seq
  import bbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_lock,
  input  logic cur_lock_end,
  input  logic bus_boff,
  input  logic bus_hold,
  input  logic bus_brdy,
  input  logic bus_na,
  input  logic last,
  output logic req_ready,
  output logic fire,
  output logic ads,
  output logic hlda,
  output logic float_o,
  output logic lock_o,
  output logic beat_ok,
  output logic na_ok,
  output logic clear,
  output logic active
);
  bbc_state_e state_q, state_d;
  logic       lock_open_q;
  logic       hold_win;
  logic       in_data;

  assign hold_win  = bus_hold & ~lock_open_q;
  assign req_ready = (state_q == ST_IDLE) & ~bus_boff & ~hold_win &
                     (~lock_open_q | req_lock);
  assign fire      = req_valid & req_ready;
  assign in_data   = (state_q == ST_DATA);
  // Back-off outranks a ready or next-address in the same clock.
  assign beat_ok   = in_data & bus_brdy & ~bus_boff;
  assign na_ok     = in_data & bus_na & ~bus_boff;
  assign active    = (state_q == ST_ADDR) | in_data;
  assign clear     = fire | (active & bus_boff);
  assign ads       = (state_q == ST_ADDR);
  assign hlda      = (state_q == ST_HOLD);
  assign float_o   = bus_boff | (state_q == ST_BOFF) | (state_q == ST_HOLD);
  assign lock_o    = lock_open_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (bus_boff)      state_d = ST_IDLE;
        else if (hold_win) state_d = ST_HOLD;
        else if (fire)     state_d = ST_ADDR;
      end
      ST_ADDR: state_d = bus_boff ? ST_BOFF : ST_DATA;
      ST_DATA: begin
        if (bus_boff)  state_d = ST_BOFF;
        else if (last) state_d = ST_IDLE;
      end
      ST_BOFF: if (!bus_boff) state_d = ST_ADDR;
      ST_HOLD: if (!bus_hold) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lock_open_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (last && cur_lock_end)  lock_open_q <= 1'b0;
      else if (fire && req_lock) lock_open_q <= 1'b1;
    end
  end

  AST_ADS_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ads |=> !ads); // R2
  AST_RESTART_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BOFF && !bus_boff) |=> ads); // R6
  AST_GRANT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> !lock_open_q); // R7
  AST_NO_GRANT_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> !hlda); // R7
  AST_HLDA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !bus_hold) |=> !hlda); // R8
  AST_LOCK_ENDS_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(last)); // R9
endmodule

// File: rtl/bbc_top.sv
module bbc_top #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BEATS = 4,
  parameter int BEAT_W     = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_cacheable,
  input  logic              req_lock,
  input  logic              req_lock_end,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BEAT_W-1:0] rsp_beat,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done,
  output logic              bus_ads,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic              bus_cache,
  output logic              bus_lock,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_brdy,
  input  logic              bus_ken,
  input  logic              bus_na,
  input  logic              bus_boff,
  input  logic              bus_hold,
  output logic              bus_hlda,
  output logic              bus_float
);
  logic fire, beat_ok, na_ok, clear, active, last;
  logic cur_line, cur_lock_end;

  bbc_req_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (fire),
    .in_addr      (req_addr),
    .in_write     (req_write),
    .in_line      (req_cacheable & ~req_write),
    .in_lock_end  (req_lock_end),
    .in_wdata     (req_wdata),
    .cur_addr     (bus_addr),
    .cur_write    (bus_write),
    .cur_line     (cur_line),
    .cur_lock_end (cur_lock_end),
    .cur_wdata    (bus_wdata)
  );

  bbc_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_lock     (req_lock),
    .cur_lock_end (cur_lock_end),
    .bus_boff     (bus_boff),
    .bus_hold     (bus_hold),
    .bus_brdy     (bus_brdy),
    .bus_na       (bus_na),
    .last         (last),
    .req_ready    (req_ready),
    .fire         (fire),
    .ads          (bus_ads),
    .hlda         (bus_hlda),
    .float_o      (bus_float),
    .lock_o       (bus_lock),
    .beat_ok      (beat_ok),
    .na_ok        (na_ok),
    .clear        (clear),
    .active       (active)
  );

  bbc_beat_ctr #(.BEATS(LINE_BEATS), .BEAT_W(BEAT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .beat_ok   (beat_ok),
    .na_ok     (na_ok),
    .ken       (bus_ken),
    .want_line (cur_line),
    .beat      (rsp_beat),
    .last      (last)
  );

  assign bus_cache = active & cur_line;
  assign rsp_valid = beat_ok;
  assign rsp_done  = last;
  assign rsp_data  = bus_rdata;

  AST_FIRST_CLK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |-> !rsp_valid); // R2
  AST_BOFF_BEATS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_boff |-> (!rsp_valid && bus_float)); // R6
  AST_DONE_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_valid); // R11
endmodule

// File: tb/bbc_top_tb_top.sv
module bbc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid = 0, req_write = 0, req_cacheable = 0;
  logic        req_lock = 0, req_lock_end = 0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_done;
  logic [1:0]  rsp_beat;
  logic [63:0] rsp_data, bus_wdata;
  logic        bus_ads, bus_write, bus_cache, bus_lock, bus_hlda, bus_float;
  logic [31:0] bus_addr;
  logic [63:0] bus_rdata = '0;
  logic        bus_brdy = 0, bus_ken = 0, bus_na = 0, bus_boff = 0, bus_hold = 0;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  bbc_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_cacheable(req_cacheable),
    .req_lock(req_lock), .req_lock_end(req_lock_end), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_beat(rsp_beat), .rsp_data(rsp_data),
    .rsp_done(rsp_done), .bus_ads(bus_ads), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_cache(bus_cache), .bus_lock(bus_lock),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_brdy(bus_brdy),
    .bus_ken(bus_ken), .bus_na(bus_na), .bus_boff(bus_boff),
    .bus_hold(bus_hold), .bus_hlda(bus_hlda), .bus_float(bus_float)
  );

  task automatic chk(input bit ok, input string r, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_data(input logic [31:0] a, input int k);
    return {a ^ 32'h5a5a_c3c3, a + 32'(k)};
  endfunction

  function automatic int exp_beats(input bit wr, input bit cach, input bit ken);
    return (cach && !wr && ken) ? 4 : 1;
  endfunction

  task automatic do_txn(input logic [31:0] a, input bit wr, input bit cach,
                        input bit lk, input bit lke, input bit ken, input bit na_early,
                        input int waits, input int boff_at, input bit hold_mid);
    int  nb;
    int  k;
    bit  restarted;
    nb = exp_beats(wr, cach, ken);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr; req_cacheable = cach;
    req_lock = lk; req_lock_end = lke; req_wdata = {~a, a};
    #1 chk(req_ready == 1'b1, "R10", req_ready, 1);
    @(negedge clk);
    req_valid = 0; bus_brdy = 1;
    #1;
    chk(bus_ads == 1'b1, "R2", bus_ads, 1);
    chk(bus_addr == a, "R2", bus_addr, a);
    chk(rsp_valid == 1'b0, "R2", rsp_valid, 0);
    chk(bus_lock == lk, "R9", bus_lock, lk);
    chk(bus_cache == (cach && !wr), "R3", bus_cache, cach && !wr);
    if (wr) chk(bus_wdata == {~a, a}, "R2", bus_wdata, {~a, a});
    if (hold_mid) bus_hold = 1;
    k = 0; restarted = 0;
    while (k < nb) begin
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        bus_brdy = 0; bus_na = na_early && k == 0 && w == 0; bus_ken = ken;
        #1 chk(rsp_valid == 1'b0, "R11", rsp_valid, 0);
      end
      @(negedge clk);
      bus_na = 0; bus_brdy = 1;
      bus_ken = (k == 0 && !na_early) ? ken : !ken;
      bus_rdata = beat_data(a, k);
      if (boff_at == k && !restarted) begin
        bus_boff = 1;
        #1;
        chk(rsp_valid == 1'b0, "R6", rsp_valid, 0);
        chk(bus_float == 1'b1, "R6", bus_float, 1);
        @(negedge clk) bus_brdy = 0;
        #1 chk(bus_float == 1'b1, "R6", bus_float, 1);
        chk(req_ready == 1'b0, "R10", req_ready, 0);
        @(negedge clk) bus_boff = 0;
        @(negedge clk);
        #1;
        chk(bus_ads == 1'b1, "R6", bus_ads, 1);
        chk(bus_addr == a, "R6", bus_addr, a);
        restarted = 1; k = 0;
        continue;
      end
      #1;
      chk(rsp_valid == 1'b1, "R11", rsp_valid, 1);
      chk(rsp_data == beat_data(a, k), "R11", rsp_data, beat_data(a, k));
      chk(rsp_beat == 2'(k), "R3", rsp_beat, k);
      chk(rsp_done == (k == nb - 1), (nb == 4) ? "R3" : "R4", rsp_done, k == nb - 1);
      chk(req_ready == 1'b0, "R10", req_ready, 0);
      if (na_early && k == 0) chk(rsp_done == (nb == 1), "R5", rsp_done, nb == 1);
      k++;
    end
    @(negedge clk);
    bus_brdy = 0; bus_ken = 0;
    #1;
    chk(bus_ads == 1'b0 && rsp_valid == 1'b0, "R4", {bus_ads, rsp_valid}, 0);
    if (lk) chk(bus_lock == !lke, "R9", bus_lock, !lke);
    if (hold_mid) begin
      chk(bus_hlda == 1'b0, "R7", bus_hlda, 0);
      chk(req_ready == 1'b0, "R10", req_ready, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nb;
    void'($urandom(32'h0bb5_1234));
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk({bus_ads, bus_hlda, bus_lock, bus_float, rsp_valid} == 5'b0, "R1",
        {bus_ads, bus_hlda, bus_lock, bus_float, rsp_valid}, 0);
    chk(req_ready == 1'b1, "R1", req_ready, 1);

    // line fill, single reads, write
    do_txn(32'h0000_1000, 0, 1, 0, 0, 1, 0, 0, -1, 0);  // R3
    do_txn(32'h0000_2000, 0, 1, 0, 0, 0, 0, 1, -1, 0);  // R4
    do_txn(32'h0000_3000, 0, 0, 0, 0, 1, 0, 0, -1, 0);  // R4
    do_txn(32'h0000_4000, 1, 1, 0, 0, 1, 0, 2, -1, 0);  // R4
    // next-address samples cache-enable first
    do_txn(32'h0000_5000, 0, 1, 0, 0, 1, 1, 1, -1, 0);  // R5
    do_txn(32'h0000_6000, 0, 1, 0, 0, 0, 1, 2, -1, 0);  // R5
    // back-off meets ready in mid burst and on a single beat
    do_txn(32'h0000_7000, 0, 1, 0, 0, 1, 0, 1, 2, 0);   // R6
    do_txn(32'h0000_8000, 1, 0, 0, 0, 0, 0, 0, 0, 0);   // R6

    // hold while idle
    @(negedge clk) bus_hold = 1;
    #1 chk(req_ready == 1'b0, "R10", req_ready, 0);
    @(negedge clk);
    #1 chk(bus_hlda == 1'b1 && bus_float == 1'b1, "R7", {bus_hlda, bus_float}, 3);
    bus_hold = 0;
    #1 chk(bus_hlda == 1'b1, "R8", bus_hlda, 1);
    @(negedge clk);
    #1 chk(bus_hlda == 1'b0, "R8", bus_hlda, 0);

    // hold raised during a cycle
    do_txn(32'h0000_9000, 0, 1, 0, 0, 1, 0, 1, -1, 1);  // R7
    @(negedge clk);
    #1 chk(bus_hlda == 1'b1, "R7", bus_hlda, 1);
    bus_hold = 0;
    @(negedge clk);
    #1 chk(bus_hlda == 1'b0, "R8", bus_hlda, 0);

    // locked sequence holds off a hold request and unlocked requests
    do_txn(32'h0000_a000, 0, 0, 1, 0, 0, 0, 1, -1, 0);  // R9
    @(negedge clk);
    bus_hold = 1; req_valid = 1; req_lock = 0;
    #1 chk(req_ready == 1'b0, "R9", req_ready, 0);
    @(negedge clk);
    req_valid = 0;
    #1;
    chk(bus_hlda == 1'b0, "R7", bus_hlda, 0);
    chk(bus_lock == 1'b1, "R9", bus_lock, 1);
    do_txn(32'h0000_b000, 1, 0, 1, 1, 0, 0, 0, 1 - 2, 0); // R9
    @(negedge clk);
    #1 chk(bus_hlda == 1'b1, "R7", bus_hlda, 1);
    bus_hold = 0;
    @(negedge clk);
    #1 chk(bus_hlda == 1'b0, "R8", bus_hlda, 0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      bit wr, cach, ken, na;
      int waits, bo;
      a     = $urandom;
      wr    = ($urandom % 4) == 0;
      cach  = $urandom % 2;
      ken   = $urandom % 2;
      na    = ($urandom % 3) == 0;
      waits = $urandom % 3;
      if (na && waits == 0) waits = 1;
      nb    = exp_beats(wr, cach, ken);
      bo    = (($urandom % 5) == 0) ? int'($urandom % nb) : -1;
      do_txn(a, wr, cach, 0, 0, ken, na, waits, bo, 0);
    end

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule